// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block decides which analog channel a successive-approximation converter samples next, and when it does so. Software supplies a per-channel enable mask, a two-bit mode, a differential flag and start/stop strobes. The sequencer asks an external converter for one conversion at a time over a request/done handshake and stores each returned sample in a result slot. Each slot has a valid flag, which a read clears, and an overrun flag.

There are four modes. A single conversion samples one channel. Burst repeats one channel, and every result goes to slot 0. A one-pass scan walks the enabled channels once. A looping scan walks them until software stops it. In differential operation, channels 2x and 2x+1 form pair x. Only even channels take part, and the result goes to the even channel's slot. At the end of a pass the block can raise a one-cycle interrupt pulse. It can also raise a one-cycle transfer-request pulse for every stored result.

Top module: `adcScanSeq`

## Requirements
- R1: After reset, startBit, convReq, eocIrq and dmaReq are 0, and every slot reads with rdValid 0.
- R2: Mode 2'b00 converts the lowest eligible channel once, stores the sample in that channel's slot and then clears startBit.
- R3: Mode 2'b01 converts the lowest eligible channel again and again, stores every sample in slot 0 and keeps startBit at 1 until startClr.
- R4: Mode 2'b10 converts every eligible channel once in ascending order and clears startBit after the highest one.
- R5: Mode 2'b11 converts the eligible channels in ascending order and wraps to the lowest after the highest. It continues until startClr.
- R6: With the differential flag set, only even enabled channels are eligible. convCh is even, convNegCh equals convCh+1, convDiff is 1 and the sample lands in the even slot.
- R7: convReq stays high with a stable convCh until convDone, and it is low in the cycle after convDone. A convDone pulse while convReq is low stores nothing.
- R8: eocIrq pulses for one cycle after a pass ends, and only when irqEn is 1. In modes 00 and 01 every conversion ends a pass. In the scan modes, the conversion of the highest eligible channel ends the pass.
- R9: dmaReq pulses for one cycle after each stored sample, and only when dmaEn is 1.
- R10: The mask, mode and differential flag are captured when the run starts. Changes to them while startBit is 1 have no effect. A start with no eligible channel leaves startBit at 0.
- R11: A stored sample sets the slot's valid flag. Writing to a slot that is still valid sets its overrun flag. A read pulse (rdEn) clears both flags.
- R12: startClr while running makes convReq and startBit 0 in the next cycle. If a convDone arrives in that same cycle, its sample is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enMask | input | NUM_CH | Channel enable mask |
| modeIn | input | 2 | Sequencing mode (00 one, 01 burst, 10 one pass, 11 looping) |
| diffEn | input | 1 | Differential pairing enable |
| startSet | input | 1 | Start strobe (ignored while running) |
| startClr | input | 1 | Stop strobe |
| irqEn | input | 1 | End-of-pass interrupt enable |
| dmaEn | input | 1 | Per-sample transfer request enable |
| startBit | output | 1 | Run in progress |
| convReq | output | 1 | Conversion request to the converter |
| convCh | output | CH_W | Selected (positive) channel |
| convNegCh | output | CH_W | Negative input channel in differential operation |
| convDiff | output | 1 | Current run is differential |
| convDone | input | 1 | Converter done pulse, data valid |
| convData | input | DATA_W | Converter sample |
| rdEn | input | 1 | Read strobe, clears the slot's flags |
| rdIdx | input | CH_W | Slot index for reading |
| rdData | output | DATA_W | Slot content |
| rdValid | output | 1 | Slot valid flag |
| rdOverrun | output | 1 | Slot overrun flag |
| eocIrq | output | 1 | End-of-pass interrupt pulse |
| dmaReq | output | 1 | Transfer request pulse |

## Verification
The assertions assume the converter pulses convDone for exactly one cycle, only while convReq is high, and never in the cycle right after a request is raised. They also assume that startSet and startClr are single-cycle pulses. The bench's converter model waits a fixed latency after it sees convReq, then returns one done pulse carrying a sample that encodes the channel and a running sequence number. It only fakes a stray done pulse while the block is idle. Strobes and register inputs change half a cycle away from the active edge, and stop strobes are timed against the done pulse on purpose.

// File: rtl/adcSeqPkg.sv
package adcSeqPkg;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'b00,
    MODE_BURST = 2'b01,
    MODE_PASS  = 2'b10,
    MODE_LOOP  = 2'b11
  } seqMode_e;

  typedef struct packed {
    logic wrEn;
    logic passEnd;
    logic toSlot0;
  } seqStrobe_t;

endpackage

// File: rtl/adcSeqCtrl.sv
module adcSeqCtrl
  import adcSeqPkg::*;
#(
  parameter int NUM_CH = 20,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] enMask,
  input  logic [1:0]        modeIn,
  input  logic              diffEn,
  input  logic              startSet,
  input  logic              startClr,
  input  logic              convDone,
  output logic              running,
  output logic              convReq,
  output logic [CH_W-1:0]   curCh,
  output logic              diffLat,
  output seqStrobe_t        stb
);

  seqMode_e          modeLat;
  logic [NUM_CH-1:0] maskLat, evenMask, eligLive;
  logic [CH_W-1:0]   firstLive, firstLat, nextCh;
  logic              hasNext, pend;

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) evenMask[i] = ((i % 2) == 0);
  end

  assign eligLive = enMask & (diffEn ? evenMask : {NUM_CH{1'b1}});

  always_comb begin
    firstLive = '0;
    firstLat  = '0;
    nextCh    = '0;
    hasNext   = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (eligLive[i]) firstLive = CH_W'(i);
      if (maskLat[i]) firstLat = CH_W'(i);
      if (maskLat[i] && (i > int'(curCh))) begin
        nextCh  = CH_W'(i);
        hasNext = 1'b1;
      end
    end
  end

  assign stb.wrEn    = convReq & convDone;
  assign stb.toSlot0 = (modeLat == MODE_BURST);
  assign stb.passEnd = stb.wrEn &
                       ((modeLat == MODE_ONE) || (modeLat == MODE_BURST) || !hasNext);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      convReq <= 1'b0;
      pend    <= 1'b0;
      curCh   <= '0;
      diffLat <= 1'b0;
      maskLat <= '0;
      modeLat <= MODE_ONE;
    end else if (!running) begin
      if (startSet && (|eligLive)) begin
        running <= 1'b1;
        convReq <= 1'b1;
        modeLat <= seqMode_e'(modeIn);
        diffLat <= diffEn;
        maskLat <= eligLive;
        curCh   <= firstLive;
      end
    end else if (startClr) begin
      running <= 1'b0;
      convReq <= 1'b0;
      pend    <= 1'b0;
    end else if (convReq && convDone) begin
      convReq <= 1'b0;
      case (modeLat)
        MODE_ONE:   running <= 1'b0;
        MODE_BURST: pend <= 1'b1;
        MODE_PASS: begin
          if (hasNext) begin
            curCh <= nextCh;
            pend  <= 1'b1;
          end else begin
            running <= 1'b0;
          end
        end
        default: begin
          curCh <= hasNext ? nextCh : firstLat;
          pend  <= 1'b1;
        end
      endcase
    end else if (pend) begin
      pend    <= 1'b0;
      convReq <= 1'b1;
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && !convDone && !startClr) |=> (convReq && $stable(curCh)));

  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && convDone) |=> !convReq);

  // R6
  diff_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convReq && diffLat) |-> !curCh[0]);

  // R12
  stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && startClr) |=> (!convReq && !running));

  // R2
  one_shot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && modeLat == MODE_ONE) |=> !running);

endmodule

// File: rtl/adcSeqData.sv
module adcSeqData
  import adcSeqPkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int DATA_W = 12,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [CH_W-1:0]   curCh,
  input  logic [DATA_W-1:0] convData,
  input  logic              irqEn,
  input  logic              dmaEn,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdOverrun,
  output logic              eocIrq,
  output logic              dmaReq
);

  logic [DATA_W-1:0] resReg [NUM_CH];
  logic [NUM_CH-1:0] validReg, ovrReg;
  logic [CH_W-1:0]   wrSlot;
  logic              rdInRange;

  assign wrSlot    = stb.toSlot0 ? '0 : curCh;
  assign rdInRange = int'(rdIdx) < NUM_CH;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validReg <= '0;
      ovrReg   <= '0;
      eocIrq   <= 1'b0;
      dmaReq   <= 1'b0;
      for (int i = 0; i < NUM_CH; i++) resReg[i] <= '0;
    end else begin
      eocIrq <= stb.passEnd & irqEn;
      dmaReq <= stb.wrEn & dmaEn;
      for (int i = 0; i < NUM_CH; i++) begin
        if (stb.wrEn && (int'(wrSlot) == i)) begin
          resReg[i]   <= convData;
          validReg[i] <= 1'b1;
          ovrReg[i]   <= ovrReg[i] | (validReg[i] & ~(rdEn && (int'(rdIdx) == i)));
        end else if (rdEn && (int'(rdIdx) == i)) begin
          validReg[i] <= 1'b0;
          ovrReg[i]   <= 1'b0;
        end
      end
    end
  end

  assign rdData    = rdInRange ? resReg[rdIdx] : '0;
  assign rdValid   = rdInRange ? validReg[rdIdx] : 1'b0;
  assign rdOverrun = rdInRange ? ovrReg[rdIdx] : 1'b0;

  // R9
  dma_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |=> !dmaReq);

  // R8
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    eocIrq |=> !eocIrq);

  // R11
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrEn && validReg[wrSlot] && !(rdEn && rdIdx == wrSlot)) |=> ovrReg[$past(wrSlot)]);

endmodule

// File: rtl/adcScanSeq.sv
module adcScanSeq
  import adcSeqPkg::*;
#(
  parameter int NUM_CH = 20,
  parameter int DATA_W = 12,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] enMask,
  input  logic [1:0]        modeIn,
  input  logic              diffEn,
  input  logic              startSet,
  input  logic              startClr,
  input  logic              irqEn,
  input  logic              dmaEn,
  output logic              startBit,
  output logic              convReq,
  output logic [CH_W-1:0]   convCh,
  output logic [CH_W-1:0]   convNegCh,
  output logic              convDiff,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdOverrun,
  output logic              eocIrq,
  output logic              dmaReq
);

  seqStrobe_t stb;
  logic       diffLat;

  adcSeqCtrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk(clk), .rstN(rstN), .enMask(enMask), .modeIn(modeIn), .diffEn(diffEn),
    .startSet(startSet), .startClr(startClr), .convDone(convDone),
    .running(startBit), .convReq(convReq), .curCh(convCh), .diffLat(diffLat), .stb(stb)
  );

  adcSeqData #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .curCh(convCh), .convData(convData),
    .irqEn(irqEn), .dmaEn(dmaEn), .rdEn(rdEn), .rdIdx(rdIdx),
    .rdData(rdData), .rdValid(rdValid), .rdOverrun(rdOverrun),
    .eocIrq(eocIrq), .dmaReq(dmaReq)
  );

  assign convDiff  = diffLat;
  assign convNegCh = diffLat ? (convCh | CH_W'(1)) : convCh;

endmodule

// File: tb/test_adcScanSeq.sv
module test_adcScanSeq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 20;
  localparam int DATA_W = 12;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int LAT = 2;
  localparam int WD_CYCLES = 20000;

  // {diff, mask, expected channel}
  localparam logic [25:0] VEC [7] = '{
    {1'b0, 20'h00001, 5'd0},
    {1'b0, 20'h00008, 5'd3},
    {1'b0, 20'h80000, 5'd19},
    {1'b0, 20'h0A0A0, 5'd5},
    {1'b1, 20'h00006, 5'd2},
    {1'b1, 20'h40000, 5'd18},
    {1'b1, 20'hC0000, 5'd18}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [NUM_CH-1:0] enMask = '0;
  logic [1:0] modeIn = 2'b00;
  logic diffEn = 1'b0, startSet = 1'b0, startClr = 1'b0, irqEn = 1'b0, dmaEn = 1'b0;
  logic startBit, convReq, convDiff, rdValid, rdOverrun, eocIrq, dmaReq;
  logic [CH_W-1:0] convCh, convNegCh;
  logic doneMdl = 1'b0, spur = 1'b0;
  logic [DATA_W-1:0] convData = '0;
  logic rdEn = 1'b0;
  logic [CH_W-1:0] rdIdx = '0;
  logic [DATA_W-1:0] rdData;

  int total = 0, bad = 0;
  int nLog = 0, eocCnt = 0, dmaCnt = 0, hsErr = 0, lat = 0, seqNo = 0;
  int logCh [64];
  int logNeg [64];
  int logDiff [64];
  int lastData [NUM_CH];
  int reqCh = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adcScanSeq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) i_adcScanSeq (
    .clk(clk), .rstN(rstN), .enMask(enMask), .modeIn(modeIn), .diffEn(diffEn),
    .startSet(startSet), .startClr(startClr), .irqEn(irqEn), .dmaEn(dmaEn),
    .startBit(startBit), .convReq(convReq), .convCh(convCh), .convNegCh(convNegCh),
    .convDiff(convDiff), .convDone(doneMdl | spur), .convData(convData),
    .rdEn(rdEn), .rdIdx(rdIdx), .rdData(rdData), .rdValid(rdValid),
    .rdOverrun(rdOverrun), .eocIrq(eocIrq), .dmaReq(dmaReq)
  );

  // converter model and pulse counters
  always @(negedge clk) begin
    eocCnt = eocCnt + int'(eocIrq);
    dmaCnt = dmaCnt + int'(dmaReq);
    if (doneMdl) begin
      doneMdl = 1'b0;
      if (convReq) hsErr = hsErr + 1;  // R7: request must drop after done
      lat = 0;
    end else if (convReq && rstN) begin
      if (lat == 0) reqCh = int'(convCh);
      else if (reqCh != int'(convCh)) hsErr = hsErr + 1;
      if (lat == LAT) begin
        seqNo = seqNo + 1;
        convData = DATA_W'(int'(convCh) * 128 + (seqNo % 128));
        lastData[convCh] = int'(convData);
        if (nLog < 64) begin
          logCh[nLog] = int'(convCh);
          logNeg[nLog] = int'(convNegCh);
          logDiff[nLog] = int'(convDiff);
        end
        nLog = nLog + 1;
        doneMdl = 1'b1;
        lat = 0;
      end else begin
        lat = lat + 1;
      end
    end else begin
      lat = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic pulseStart();
    startSet = 1'b1; tick(1); startSet = 1'b0;
  endtask

  task automatic pulseStop();
    startClr = 1'b1; tick(1); startClr = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 400 && startBit; k++) tick(1);
  endtask

  task automatic waitLog(input int n);
    for (int k = 0; k < 400 && nLog < n; k++) tick(1);
  endtask

  task automatic peek(input int idx);
    rdIdx = CH_W'(idx); #1;
  endtask

  task automatic drain();
    for (int i = 0; i < NUM_CH; i++) begin
      rdIdx = CH_W'(i); rdEn = 1'b1; tick(1);
    end
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
    finishRun();
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    check(!startBit && !convReq && !eocIrq && !dmaReq, "R1 outputs",
          int'({startBit, convReq, eocIrq, dmaReq}), 0);
    begin
      int vcnt = 0;
      for (int i = 0; i < NUM_CH; i++) begin peek(i); vcnt += int'(rdValid); end
      check(vcnt == 0, "R1 valid flags", vcnt, 0);
    end

    // R2/R6/R8 table walk in single mode
    irqEn = 1'b1;
    foreach (VEC[v]) begin
      int expCh;
      expCh = int'(VEC[v][4:0]);
      diffEn = VEC[v][25];
      enMask = VEC[v][24:5];
      modeIn = 2'b00;
      nLog = 0; eocCnt = 0;
      pulseStart();
      waitIdle();
      tick(2);
      check(nLog == 1 && logCh[0] == expCh, "R2 channel", logCh[0], expCh);
      if (VEC[v][25]) check(logNeg[0] == expCh + 1 && logDiff[0] == 1, "R6 neg channel", logNeg[0], expCh + 1);
      peek(expCh);
      check(rdValid && int'(rdData) == lastData[expCh], "R2 result slot", int'(rdData), lastData[expCh]);
      check(eocCnt == 1, "R8 eoc per single", eocCnt, 1);
      drain();
    end

    // R4 + R10: one pass scan, inputs changed mid-run
    diffEn = 1'b0; enMask = 20'h00125; modeIn = 2'b10;
    nLog = 0; eocCnt = 0;
    pulseStart();
    modeIn = 2'b11; diffEn = 1'b1; enMask = '0;
    waitIdle();
    tick(2);
    check(nLog == 4, "R10 captured config count", nLog, 4);
    check(logCh[0] == 0 && logCh[1] == 2 && logCh[2] == 5 && logCh[3] == 8, "R4 order",
          logCh[2], 5);
    check(eocCnt == 1, "R8 eoc per pass", eocCnt, 1);
    peek(5);
    check(rdValid && int'(rdData) == lastData[5], "R4 slot 5", int'(rdData), lastData[5]);
    drain();

    // R6: differential pass skips odd channels
    diffEn = 1'b1; enMask = 20'h0000F; modeIn = 2'b10;
    nLog = 0;
    pulseStart();
    waitIdle();
    tick(2);
    check(nLog == 2 && logCh[0] == 0 && logCh[1] == 2, "R6 pass order", logCh[1], 2);
    peek(1);
    check(!rdValid, "R6 odd slot untouched", int'(rdValid), 0);
    drain();

    // R5 + R9 + R8 gating + R12: looping scan stopped on a done pulse
    diffEn = 1'b0; enMask = 20'h00012; modeIn = 2'b11;
    irqEn = 1'b0; dmaEn = 1'b1;
    nLog = 0; eocCnt = 0; dmaCnt = 0;
    pulseStart();
    waitLog(5);
    startClr = 1'b1; tick(1); startClr = 1'b0;
    check(!convReq && !startBit, "R12 stop", int'({convReq, startBit}), 0);
    tick(8);
    check(nLog == 5 && logCh[0] == 1 && logCh[1] == 4 && logCh[2] == 1 && logCh[3] == 4 && logCh[4] == 1,
          "R5 wrap order", logCh[2], 1);
    check(dmaCnt == 5, "R9 dma pulses", dmaCnt, 5);
    check(eocCnt == 0, "R8 irq disabled", eocCnt, 0);
    peek(1);
    check(rdValid && int'(rdData) == lastData[1], "R12 last sample stored", int'(rdData), lastData[1]);
    drain();

    // R3 + R11: burst into slot 0
    enMask = 20'h00300; modeIn = 2'b01; irqEn = 1'b1; dmaEn = 1'b0;
    nLog = 0; eocCnt = 0; dmaCnt = 0;
    pulseStart();
    waitLog(2);
    check(startBit == 1'b1, "R3 still running", int'(startBit), 1);
    waitLog(3);
    pulseStop();
    tick(4);
    check(nLog == 3 && logCh[0] == 8 && logCh[1] == 8 && logCh[2] == 8, "R3 channel", logCh[2], 8);
    check(eocCnt == 3 && dmaCnt == 0, "R8 eoc per burst sample", eocCnt, 3);
    peek(0);
    check(rdValid && int'(rdData) == lastData[8], "R3 slot 0 data", int'(rdData), lastData[8]);
    check(rdOverrun == 1'b1, "R11 overrun set", int'(rdOverrun), 1);
    peek(8);
    check(!rdValid, "R3 slot 8 empty", int'(rdValid), 0);
    rdIdx = '0; rdEn = 1'b1; tick(1); rdEn = 1'b0;
    peek(0);
    check(!rdValid && !rdOverrun, "R11 read clears", int'({rdValid, rdOverrun}), 0);

    // R10: start with nothing eligible
    diffEn = 1'b1; enMask = 20'h00002; modeIn = 2'b00;
    nLog = 0;
    pulseStart();
    tick(3);
    check(!startBit && nLog == 0, "R10 empty start", int'(startBit), 0);

    // R7: stray done while idle
    dmaEn = 1'b1; dmaCnt = 0;
    spur = 1'b1; tick(1); spur = 1'b0; tick(2);
    begin
      int vcnt = 0;
      for (int i = 0; i < NUM_CH; i++) begin peek(i); vcnt += int'(rdValid); end
      check(vcnt == 0 && dmaCnt == 0, "R7 stray done ignored", vcnt, 0);
    end
    check(hsErr == 0, "R7 handshake", hsErr, 0);

    finishRun();
  end
endmodule